// File: doc/BRIEF.md
# Parallel-Port Block Read Engine

This engine sits on the device side of a parallel-port link to an IDE drive and streams a run of bytes from the drive's data register back to the host. The host first selects a target with an address-latch handshake on the control lines. During that handshake the data lines carry an address byte. Its upper two bits pick how the bytes come back, and its low bits select the drive register. The host then pulls bytes one by one until it ends the burst.

Three return styles are supported. In nibble style, each byte reaches the host in two halves on four status lines. In byte style, the engine drives the data lines itself on each step of an alternating control pattern. In strobe-cycle style, each host read strobe returns one byte. The host's last two strobe reads of a burst come after its end-of-burst control pattern, so the engine keeps two bytes fetched ahead of the host. A mode and byte-count status output lets the surrounding logic follow the burst.

Top module: `pp_block_reader`

## Requirements
- R1: After reset the data lines are released (`pd_oe`=0), `busy`=0, `blk_count`=0, `nib_o`=0 and no drive read is issued.
- R2: A control step to 0x0C followed by a step to 0x0E latches `pd_i` as the address byte. The next step to 0x04 starts a burst. Address bits [7:6] appear on `blk_mode`: 00 nibble, 11 byte, 10 strobe-cycle. The low bits appear on `ide_reg`.
- R3: In nibble style, each control step to 0x06 issues one drive read and shows bits [3:0] of the new byte on `nib_o`. The following step from 0x06 to 0x04 shows bits [7:4].
- R4: In byte style, requests alternate between control 0xA6 and 0xA4, starting with 0xA6. Each request issues one drive read and places the byte on `pd_o`. A step to 0xA4 where 0xA6 is expected is ignored.
- R5: In strobe-cycle style, the engine reads two bytes ahead when the burst starts. Each rising edge of `epp_rd_i` delivers the oldest fetched byte on `pd_o` and issues one refill read.
- R6: The end pattern (a step to 0xAC, then a step to 0xA4) issues no drive read.
- R7: After the end pattern in strobe-cycle style, two more strobes deliver the two prefetched bytes without drive reads. The following step to 0x04 ends the burst (`busy`=0).
- R8: `pd_oe` is high only during a byte-style burst while control bit 5 is set, or during a strobe-cycle burst while `epp_rd_i` is high. The lines are released once the burst ends on 0x04.
- R9: `blk_count` counts bytes delivered in the current burst (a nibble byte counts when its upper half is shown) and clears on the next address handshake.
- R10: An address with bits [7:6] = 01 starts no burst: later control steps issue no reads and leave `pd_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_i | input | 8 | Host control byte |
| pd_i | input | 8 | Host data lines, inbound |
| pd_o | output | 8 | Data lines, outbound byte |
| pd_oe | output | 1 | Outbound drive enable for the data lines |
| epp_rd_i | input | 1 | Host strobe for a strobe-cycle data read |
| nib_o | output | 4 | Nibble shown on the host status lines |
| ide_rd | output | 1 | One-cycle drive data-register read |
| ide_reg | output | REG_W | Drive register select from the address byte |
| ide_rdata | input | 8 | Drive read data, valid in the `ide_rd` cycle |
| blk_mode | output | 2 | Transfer style from address bits [7:6] |
| blk_count | output | CNT_W | Bytes delivered in the current burst |
| busy | output | 1 | A burst is in progress |

## Verification
The hardest case to reach from the ports is the end of a strobe-cycle burst. A wrong prefetch depth or refill rule only shows up as a byte-count or data error after the end pattern, when no more reads may be issued. The stimulus runs full 512-byte bursts and a minimal 4-byte burst. It compares the total number of drive reads with the burst length exactly, and checks the two tail bytes delivered after the end pattern. A directed case sends the second alternating byte-style value first, to show that it is ignored.

// File: rtl/pp_block_reader.sv
module pp_block_reader #(
  parameter int CNT_W = 16,
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctl_i,
  input  logic [7:0]       pd_i,
  output logic [7:0]       pd_o,
  output logic             pd_oe,
  input  logic             epp_rd_i,
  output logic [3:0]       nib_o,
  output logic             ide_rd,
  output logic [REG_W-1:0] ide_reg,
  input  logic [7:0]       ide_rdata,
  output logic [1:0]       blk_mode,
  output logic [CNT_W-1:0] blk_count,
  output logic             busy
);
  localparam logic [7:0] C_LAT0 = 8'h0C;
  localparam logic [7:0] C_LAT1 = 8'h0E;
  localparam logic [7:0] C_REST = 8'h04;
  localparam logic [7:0] C_NLO  = 8'h06;
  localparam logic [7:0] C_BA   = 8'hA6;
  localparam logic [7:0] C_BB   = 8'hA4;
  localparam logic [7:0] C_END  = 8'hAC;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ADDR, S_NIB, S_BYTE, S_BT1, S_BT2, S_EPP, S_ET1, S_ET2
  } st_t;

  st_t              st;
  logic [7:0]       ctl_q, addr_q, cur_q, out_q, f0_q, f1_q;
  logic [1:0]       fcnt_q;
  logic             need_q, exp_q, epp_q;
  logic [3:0]       nib_q;
  logic [CNT_W-1:0] cnt_q;

  wire ev     = ctl_i != ctl_q;
  wire e_lat0 = ev && ctl_i == C_LAT0;
  wire e_lat1 = ev && ctl_i == C_LAT1;
  wire e_go   = ev && ctl_i == C_REST;
  wire e_nlo  = ev && ctl_i == C_NLO;
  wire e_ba   = ev && ctl_i == C_BA;
  wire e_bb   = ev && ctl_i == C_BB;
  wire e_end  = ev && ctl_i == C_END;

  wire in_byte  = st inside {S_BYTE, S_BT1, S_BT2};
  wire in_epp   = st inside {S_EPP, S_ET1, S_ET2};
  wire epp_rise = epp_rd_i && !epp_q;

  wire nib_fetch = st == S_NIB && e_nlo && need_q;
  wire nib_high  = st == S_NIB && e_go && ctl_q == C_NLO && !need_q;
  wire byte_req  = st == S_BYTE && (exp_q ? e_bb : e_ba);
  wire epp_pop   = in_epp && epp_rise && fcnt_q != 2'd0;
  wire epp_fill  = st == S_EPP && !e_end && (fcnt_q != 2'd2 || epp_pop);

  assign ide_rd    = nib_fetch || byte_req || epp_fill;
  assign pd_oe     = (in_byte && ctl_i[5]) || (in_epp && epp_rd_i);
  assign pd_o      = out_q;
  assign nib_o     = nib_q;
  assign ide_reg   = addr_q[REG_W-1:0];
  assign blk_mode  = addr_q[7:6];
  assign blk_count = cnt_q;
  assign busy      = st inside {S_NIB, S_BYTE, S_BT1, S_BT2, S_EPP, S_ET1, S_ET2};

  always_ff @(posedge clk) begin
    if (!rst_n) epp_q <= 1'b0;
    else        epp_q <= epp_rd_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ctl_q  <= C_REST;
      addr_q <= 8'h00;
      cur_q  <= 8'h00;
      out_q  <= 8'h00;
      f0_q   <= 8'h00;
      f1_q   <= 8'h00;
      fcnt_q <= 2'd0;
      need_q <= 1'b0;
      exp_q  <= 1'b0;
      nib_q  <= 4'h0;
      cnt_q  <= '0;
    end else begin
      ctl_q <= ctl_i;
      if (e_lat0 && st != S_ADDR) begin
        st     <= S_PRE;
        cnt_q  <= '0;
        fcnt_q <= 2'd0;
      end else if (e_lat1 && (st == S_PRE || st == S_ADDR)) begin
        addr_q <= pd_i;
        st     <= S_ADDR;
      end else begin
        case (st)
          S_ADDR: if (e_go) begin
            case (addr_q[7:6])
              2'b00: begin st <= S_NIB; need_q <= 1'b1; end
              2'b11: begin st <= S_BYTE; exp_q <= 1'b0; end
              2'b10: begin st <= S_EPP; fcnt_q <= 2'd0; end
              default: st <= S_IDLE;
            endcase
          end
          S_NIB: begin
            if (nib_fetch) begin
              cur_q  <= ide_rdata;
              nib_q  <= ide_rdata[3:0];
              need_q <= 1'b0;
            end else if (e_nlo) begin
              nib_q <= cur_q[3:0];
            end else if (nib_high) begin
              nib_q  <= cur_q[7:4];
              need_q <= 1'b1;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
          S_BYTE: begin
            if (byte_req) begin
              out_q <= ide_rdata;
              exp_q <= ~exp_q;
              cnt_q <= cnt_q + 1'b1;
            end else if (e_end) begin
              st <= S_BT1;
            end
          end
          S_BT1: if (e_bb) st <= S_BT2;
          S_BT2: if (e_go) st <= S_IDLE;
          S_EPP, S_ET1, S_ET2: begin
            if (epp_pop) begin
              out_q <= f0_q;
              cnt_q <= cnt_q + 1'b1;
            end
            case ({epp_pop, epp_fill})
              2'b11: begin
                if (fcnt_q == 2'd2) begin
                  f0_q <= f1_q;
                  f1_q <= ide_rdata;
                end else begin
                  f0_q <= ide_rdata;
                end
              end
              2'b01: begin
                if (fcnt_q == 2'd0) f0_q <= ide_rdata;
                else                f1_q <= ide_rdata;
                fcnt_q <= fcnt_q + 2'd1;
              end
              2'b10: begin
                f0_q   <= f1_q;
                fcnt_q <= fcnt_q - 2'd1;
              end
              default: ;
            endcase
            if (st == S_EPP && e_end)    st <= S_ET1;
            else if (st == S_ET1 && e_bb) st <= S_ET2;
            else if (st == S_ET2 && e_go) st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_FIFO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q != 2'd3); // R5
  AST_EPP_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EPP && fcnt_q == 2'd2 && !epp_rise) |-> !ide_rd); // R5
  AST_NO_RD_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_BT1, S_BT2, S_ET1, S_ET2}) |-> !ide_rd); // R6
  AST_NIB_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_rd && st == S_NIB) |-> (ctl_i == C_NLO && ctl_q != C_NLO)); // R3
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BT2 && e_go) |=> !pd_oe); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0)); // R9
endmodule

// File: tb/tb_pp_block_reader.sv
module tb_pp_block_reader;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int REG_W = 6;
  localparam int NVEC = 5;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h08_0200, 24'hC8_0200, 24'h88_0200, 24'h10_0040, 24'h90_0004
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       ctl_i = 8'h04;
  logic [7:0]       pd_i = 8'h00;
  logic             epp_rd_i = 1'b0;
  logic [7:0]       pd_o;
  logic             pd_oe;
  logic [3:0]       nib_o;
  logic             ide_rd;
  logic [REG_W-1:0] ide_reg;
  logic [7:0]       ide_rdata;
  logic [1:0]       blk_mode;
  logic [CNT_W-1:0] blk_count;
  logic             busy;
  logic [15:0]      idx;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_block_reader #(.CNT_W(CNT_W), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .pd_i(pd_i), .pd_o(pd_o),
    .pd_oe(pd_oe), .epp_rd_i(epp_rd_i), .nib_o(nib_o), .ide_rd(ide_rd),
    .ide_reg(ide_reg), .ide_rdata(ide_rdata), .blk_mode(blk_mode),
    .blk_count(blk_count), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= 16'd0;
    else if (ide_rd) idx <= idx + 16'd1;
  end
  assign ide_rdata = idx[7:0];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk) ctl_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic latch(input logic [7:0] a);
    @(negedge clk) pd_i = a;
    set_ctl(8'h0C);
    set_ctl(8'h0E);
    set_ctl(8'h0C);
    set_ctl(8'h04);
  endtask

  task automatic strobe(output logic [7:0] b, output logic oe);
    @(negedge clk) epp_rd_i = 1'b1;
    repeat (2) @(negedge clk);
    b = pd_o;
    oe = pd_oe;
    epp_rd_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [7:0] a, input int n);
    int base;
    int mism;
    int mism128;
    logic [7:0] got;
    logic oe;
    logic [3:0] lo;
    base = int'(idx);
    mism = 0;
    mism128 = 0;
    latch(a);
    chk(blk_mode == a[7:6] && ide_reg == a[5:0], "R2", "mode/reg",
        int'({blk_mode, ide_reg}), int'(a));
    case (a[7:6])
      2'b00: begin
        for (int k = 0; k < n; k++) begin
          set_ctl(8'h06);
          lo = nib_o;
          if (pd_oe) mism++;
          set_ctl(8'h04);
          got = {nib_o, lo};
          if (got != 8'((base + k) & 255)) begin
            mism++;
            if (k < 128) mism128++;
          end
        end
        chk(mism == 0 && mism128 == 0, "R3", "nibble data errors", mism, 0);
      end
      2'b11: begin
        pd_i = 8'hFF;
        for (int k = 0; k < n; k++) begin
          set_ctl((k % 2 == 0) ? 8'hA6 : 8'hA4);
          if (!pd_oe) mism++;
          if (pd_o != 8'((base + k) & 255)) begin
            mism++;
            if (k < 128) mism128++;
          end
        end
        chk(mism == 0 && mism128 == 0, "R4 R8", "byte data errors", mism, 0);
        set_ctl(8'hAC);
        set_ctl(8'hA4);
        chk(int'(idx) - base == n, "R6", "reads after end pattern",
            int'(idx) - base, n);
        set_ctl(8'h04);
        chk(!pd_oe && !busy, "R8", "released after burst", int'(pd_oe), 0);
      end
      default: begin
        for (int k = 0; k < n - 2; k++) begin
          strobe(got, oe);
          if (!oe) mism++;
          if (got != 8'((base + k) & 255)) begin
            mism++;
            if (k < 128) mism128++;
          end
        end
        chk(int'(idx) - base == n, "R5", "reads before end pattern",
            int'(idx) - base, n);
        set_ctl(8'hAC);
        set_ctl(8'hA4);
        for (int k = n - 2; k < n; k++) begin
          strobe(got, oe);
          if (!oe || got != 8'((base + k) & 255)) mism++;
        end
        chk(mism == 0 && mism128 == 0, "R5 R7", "strobe data errors", mism, 0);
        chk(int'(idx) - base == n, "R7", "tail issued no reads",
            int'(idx) - base, n);
        set_ctl(8'h04);
        chk(!busy && !pd_oe, "R7", "burst ended", int'(busy), 0);
      end
    endcase
    chk(int'(blk_count) == n, "R9", "byte count", int'(blk_count), n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(!pd_oe && !busy && blk_count == 0 && nib_o == 4'h0 && !ide_rd,
        "R1", "reset state", int'({pd_oe, busy, ide_rd}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][23:16], int'(VEC[v][15:0]));

    base = int'(idx);
    latch(8'hC8);
    chk(blk_count == 0, "R9", "count cleared by new address", int'(blk_count), 0);
    pd_i = 8'hFF;
    set_ctl(8'hA4);
    chk(int'(idx) == base && blk_count == 0, "R4", "0xA4 first ignored",
        int'(idx) - base, 0);
    set_ctl(8'hA6);
    chk(int'(idx) == base + 1 && pd_o == 8'(base & 255), "R4", "0xA6 accepted",
        int'(pd_o), base & 255);
    set_ctl(8'hAC);
    set_ctl(8'hA4);
    set_ctl(8'h04);
    chk(int'(idx) == base + 1, "R6", "end pattern no reads", int'(idx) - base, 1);

    base = int'(idx);
    latch(8'h48);
    set_ctl(8'h06);
    set_ctl(8'hA6);
    chk(int'(idx) == base && !pd_oe && !busy, "R10", "inert address",
        int'(idx) - base, 0);
    set_ctl(8'h04);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule